// File: doc/BRIEF.md
# Key-protected independent watchdog

This block is a watchdog timer whose down-counter runs on its own slow clock, separate from the bus clock that software uses to reach it. Software talks to it through four small registers on the bus clock. One is a write-only command register that takes 16-bit magic values. The others are a 3-bit divider select, a 12-bit reload value and a 2-bit busy status. Once started, the watchdog can only be returned to idle by a system reset. If software does not refresh it in time, it drives a reset pulse that lasts a set number of slow-clock cycles.

The divider select and the reload value are write-protected. An unlock command opens them. Any other command value closes them again. Each accepted write is carried into the slow domain by a toggle handshake through two-flop synchronizers. The matching status bit stays set until the slow side has captured the value and its acknowledge has come back. While the bit is set, further writes to that register are dropped.

The expiry period is the divider times the reload value, counted in slow-clock cycles. The divider is 4 << min(code, 6), so it runs from 4 to 256.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the divider select reads 0, the reload value reads 4095 (0xFFF), status reads 0 and `wdg_rst` is low. Register addresses are: 0 command, 1 divider select (bits 2:0), 2 reload (bits 11:0), 3 status.
- R2: While protected, writes to the divider select or reload register are ignored and their read values stay unchanged. Protection is active after reset.
- R3: Writing 0x5555 to the command register removes write protection. Writing any other value to the command register restores it.
- R4: An accepted write sets a status bit: bit 0 for the divider select, bit 1 for the reload value. The bit clears by itself after the value has crossed into the slow domain and been acknowledged. While the bit is set, writes to that register are ignored.
- R5: Divider codes 0 to 5 select division by 4, 8, 16, 32, 64 and 128. Codes 6 and 7 both select division by 256.
- R6: No reset pulse appears before the start command 0xCCCC. Once started, successive rising edges of `wdg_rst` are exactly divider × reload slow-clock cycles apart.
- R7: Writing 0xAAAA reloads the down-counter and restarts the divider. If this is repeated faster than the expiry period, no pulse appears. When it stops, a pulse follows.
- R8: Each reset pulse is high for exactly RST_LEN slow-clock cycles.
- R9: Once started, no command value stops the watchdog. Pulses continue after any command writes.
- R10: A reload value of 0 behaves as 1, giving a pulse every divider cycles.
- R11: The command register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | Independent slow clock driving the divider and counter |
| reg_wr | input | 1 | Write strobe, one bus cycle per write |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| wdg_rst | output | 1 | Watchdog reset pulse, slow-clock domain |

## Verification
The bench uses the default parameters: a 12-bit counter, two synchronizer stages and a two-cycle pulse. Because the smallest divider is 4 and the reload value can be set as low as 0, every divider code, including both codes that select 256, gives a pulse period of a few hundred slow cycles at most. The period can therefore be measured exactly edge to edge. The slow clock is not related to the bus clock, so the busy flags are seen set and later cleared through real synchronizer latency. Refresh timing is likewise exercised against an expiry period of 80 slow cycles.

// File: rtl/kw_pkg.sv
package kw_pkg;
  localparam int DATA_W       = 16;
  localparam int PSC_W        = 3;
  localparam int MIN_DIV_LOG2 = 2;
  localparam int MAX_SHIFT    = 6;
  localparam int DIV_W        = MIN_DIV_LOG2 + MAX_SHIFT;

  localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;

  typedef enum logic [1:0] {
    ADR_KEY  = 2'd0,
    ADR_PSC  = 2'd1,
    ADR_RLD  = 2'd2,
    ADR_STAT = 2'd3
  } kw_addr_e;

  // terminal count of the divider (divide ratio minus one) for a code
  function automatic logic [DIV_W-1:0] div_last(input logic [PSC_W-1:0] code);
    int sh;
    logic [31:0] v;
    sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
    v  = (32'd1 << (sh + MIN_DIV_LOG2)) - 32'd1;
    return v[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/kw_sync.sv
module kw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/kw_xfer.sv
// Carries one register value from the bus domain into the slow domain with a
// toggle request and a synchronized acknowledge. The source value must stay
// stable while busy_o is high.
module kw_xfer #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         bus_clk,
  input  logic         bus_rst_n,
  input  logic         slow_clk,
  input  logic         slow_rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic [W-1:0] data_o
);
  logic         req_q, req_d;
  logic         req_s;
  logic         seen_q, seen_d;
  logic         ack_s;
  logic         cap;
  logic [W-1:0] shadow_q, shadow_d;

  // bus side: request toggle
  always_comb req_d = req_q ^ load_i;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) req_q <= 1'b0;
    else            req_q <= req_d;
  end

  kw_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(slow_clk), .rst_n(slow_rst_n), .d(req_q), .q(req_s)
  );

  // slow side: capture on request change
  always_comb begin
    cap      = req_s ^ seen_q;
    seen_d   = req_s;
    shadow_d = cap ? data_i : shadow_q;
  end

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      seen_q   <= 1'b0;
      shadow_q <= RST_VAL;
    end else begin
      seen_q   <= seen_d;
      if (cap) shadow_q <= shadow_d;
    end
  end

  kw_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(seen_q), .q(ack_s)
  );

  assign busy_o = req_q ^ ack_s;
  assign data_o = shadow_q;
endmodule

// File: rtl/kw_bus_regs.sv
module kw_bus_regs
  import kw_pkg::*;
#(
  parameter int RLD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              psc_busy_i,
  input  logic              rld_busy_i,
  output logic [PSC_W-1:0]  psc_o,
  output logic [RLD_W-1:0]  rld_o,
  output logic              psc_load_o,
  output logic              rld_load_o,
  output logic              started_o,
  output logic              unlocked_o,
  output logic              refresh_tog_o
);
  logic             key_wr;
  logic             unlocked_q, unlocked_d;
  logic             started_q, started_d;
  logic             refresh_q, refresh_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [RLD_W-1:0] rld_q, rld_d;
  logic             psc_load, rld_load;

  always_comb begin
    key_wr     = wr_i && (addr_i == ADR_KEY);
    psc_load   = wr_i && (addr_i == ADR_PSC) && unlocked_q && !psc_busy_i;
    rld_load   = wr_i && (addr_i == ADR_RLD) && unlocked_q && !rld_busy_i;
    unlocked_d = key_wr ? (wdata_i == KEY_UNLOCK) : unlocked_q;
    started_d  = started_q | (key_wr && (wdata_i == KEY_START));
    refresh_d  = refresh_q ^ (key_wr && (wdata_i == KEY_REFRESH));
    psc_d      = psc_load ? wdata_i[PSC_W-1:0] : psc_q;
    rld_d      = rld_load ? wdata_i[RLD_W-1:0] : rld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      started_q  <= 1'b0;
      refresh_q  <= 1'b0;
      psc_q      <= '0;
      rld_q      <= '1;
    end else begin
      unlocked_q <= unlocked_d;
      started_q  <= started_d;
      refresh_q  <= refresh_d;
      if (psc_load) psc_q <= psc_d;
      if (rld_load) rld_q <= rld_d;
    end
  end

  always_comb begin
    case (addr_i)
      ADR_PSC:  rdata_o = DATA_W'(psc_q);
      ADR_RLD:  rdata_o = DATA_W'(rld_q);
      ADR_STAT: rdata_o = DATA_W'({rld_busy_i, psc_busy_i});
      default:  rdata_o = '0;
    endcase
  end

  assign psc_o         = psc_q;
  assign rld_o         = rld_q;
  assign psc_load_o    = psc_load;
  assign rld_load_o    = rld_load;
  assign started_o     = started_q;
  assign unlocked_o    = unlocked_q;
  assign refresh_tog_o = refresh_q;
endmodule

// File: rtl/kw_slow_core.sv
module kw_slow_core
  import kw_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int RST_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             refresh_tog_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             wdg_rst_o
);
  localparam int LEN_W = $clog2(RST_LEN + 1);

  logic             seen_q;
  logic             refresh_p;
  logic [DIV_W-1:0] last;
  logic [DIV_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             rst_q, rst_d;
  logic             tick, expire;

  always_comb begin
    refresh_p = refresh_tog_i ^ seen_q;
    last      = div_last(psc_i);
    tick      = run_i && (pre_q >= last);
    expire    = tick && !refresh_p && (cnt_q <= CNT_W'(1));

    if (!run_i || refresh_p || tick) pre_d = '0;
    else                             pre_d = pre_q + DIV_W'(1);

    if (!run_i || refresh_p) cnt_d = reload_i;
    else if (tick)           cnt_d = (cnt_q <= CNT_W'(1)) ? reload_i : cnt_q - CNT_W'(1);
    else                     cnt_d = cnt_q;

    if (expire)             len_d = LEN_W'(RST_LEN);
    else if (len_q != '0)   len_d = len_q - LEN_W'(1);
    else                    len_d = '0;

    rst_d = (len_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '1;
      len_q  <= '0;
      rst_q  <= 1'b0;
    end else begin
      seen_q <= refresh_tog_i;
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      rst_q  <= rst_d;
    end
  end

  assign wdg_rst_o = rst_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kw_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int RST_LEN     = 2
) (
  input  logic              bus_clk,
  input  logic              arst_n,
  input  logic              slow_clk,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdg_rst
);
  logic             bus_rst_n, slow_rst_n;
  logic [PSC_W-1:0] psc_q, psc_slow;
  logic [CNT_W-1:0] rld_q, rld_slow;
  logic             psc_load, rld_load;
  logic             psc_busy, rld_busy;
  logic             started, unlocked, refresh_tog;
  logic             run_s, refresh_s;

  // reset released synchronously in each domain
  kw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_bus_rst (
    .clk(bus_clk), .rst_n(arst_n), .d(1'b1), .q(bus_rst_n)
  );
  kw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_slow_rst (
    .clk(slow_clk), .rst_n(arst_n), .d(1'b1), .q(slow_rst_n)
  );

  kw_bus_regs #(.RLD_W(CNT_W)) u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .psc_busy_i(psc_busy), .rld_busy_i(rld_busy),
    .psc_o(psc_q), .rld_o(rld_q),
    .psc_load_o(psc_load), .rld_load_o(rld_load),
    .started_o(started), .unlocked_o(unlocked), .refresh_tog_o(refresh_tog)
  );

  kw_xfer #(.W(PSC_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_psc_xfer (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .load_i(psc_load), .data_i(psc_q), .busy_o(psc_busy), .data_o(psc_slow)
  );

  kw_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_rld_xfer (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .load_i(rld_load), .data_i(rld_q), .busy_o(rld_busy), .data_o(rld_slow)
  );

  kw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_cmd_sync (
    .clk(slow_clk), .rst_n(slow_rst_n),
    .d({started, refresh_tog}), .q({run_s, refresh_s})
  );

  kw_slow_core #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_core (
    .clk(slow_clk), .rst_n(slow_rst_n),
    .run_i(run_s), .refresh_tog_i(refresh_s),
    .psc_i(psc_slow), .reload_i(rld_slow),
    .wdg_rst_o(wdg_rst)
  );
endmodule

// File: rtl/kw_checker.sv
module kw_checker
  import kw_pkg::*;
#(
  parameter int RST_LEN = 2
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              slow_clk,
  input logic              slow_rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              unlocked,
  input logic [PSC_W-1:0]  psc_q,
  input logic              psc_load,
  input logic              psc_busy,
  input logic              rld_load,
  input logic              rld_busy,
  input logic              started,
  input logic              run_s,
  input logic              wdg_rst
);
  AST_LOCKED_PSC_HOLDS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (reg_wr && reg_addr == ADR_PSC && !unlocked) |=> $stable(psc_q)); // R2

  AST_OTHER_KEY_LOCKS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (reg_wr && reg_addr == ADR_KEY && reg_wdata != KEY_UNLOCK) |=> !unlocked); // R3

  AST_PSC_BUSY_SETS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    psc_load |=> psc_busy); // R4

  AST_RLD_BUSY_SETS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rld_load |=> rld_busy); // R4

  AST_BUSY_FREEZES_PSC: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    psc_busy |=> $stable(psc_q)); // R4

  AST_START_STICKS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    started |=> started); // R9

  AST_IDLE_NO_PULSE: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    !run_s |-> !wdg_rst); // R6

  if (RST_LEN > 1) begin : g_width
    AST_PULSE_HOLDS: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      $rose(wdg_rst) |=> wdg_rst); // R8
  end
endmodule

bind keyed_watchdog kw_checker #(.RST_LEN(RST_LEN)) u_kw_checker (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
  .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .unlocked(unlocked), .psc_q(psc_q), .psc_load(psc_load), .psc_busy(psc_busy),
  .rld_load(rld_load), .rld_busy(rld_busy),
  .started(started), .run_s(run_s), .wdg_rst(wdg_rst)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = 26;
  localparam int RST_LEN     = 2;
  localparam int NVEC        = 9;

  typedef struct packed {
    logic [2:0]  code;
    logic [11:0] rld;
    logic [15:0] period;
  } vec_t;

  // divider code, reload value, expected slow cycles between pulses
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 12'd3, 16'd12},   // R5 code 0 -> /4
    '{3'd1, 12'd2, 16'd16},   // R5 code 1 -> /8
    '{3'd2, 12'd1, 16'd16},   // R5 code 2 -> /16
    '{3'd3, 12'd1, 16'd32},   // R5 code 3 -> /32
    '{3'd4, 12'd1, 16'd64},   // R5 code 4 -> /64
    '{3'd5, 12'd1, 16'd128},  // R5 code 5 -> /128
    '{3'd6, 12'd1, 16'd256},  // R5 code 6 -> /256
    '{3'd7, 12'd2, 16'd512},  // R5 code 7 -> /256
    '{3'd0, 12'd0, 16'd4}     // R10 reload 0 acts as 1
  };

  logic        bus_clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        arst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        wdg_rst;

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

  keyed_watchdog #(.RST_LEN(RST_LEN)) i_keyed_watchdog (
    .bus_clk(bus_clk), .arst_n(arst_n), .slow_clk(slow_clk),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wdg_rst(wdg_rst)
  );

  int total = 0;
  int bad   = 0;

  // pulse monitor in slow cycles, sampled away from the active edge
  int   scyc = 0, last_rise = 0, last_int = -1, pulses = 0, hi_run = 0, last_width = 0;
  logic prev = 1'b0;
  always @(negedge slow_clk) begin
    scyc = scyc + 1;
    if (wdg_rst === 1'b1) hi_run = hi_run + 1;
    else begin
      if (prev) last_width = hi_run;
      hi_run = 0;
    end
    if (wdg_rst === 1'b1 && !prev) begin
      last_int  = scyc - last_rise;
      last_rise = scyc;
      pulses    = pulses + 1;
    end
    prev = (wdg_rst === 1'b1);
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge bus_clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge bus_clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge bus_clk);
    reg_wr = 1'b0; reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic wait_idle();
    int s;
    for (int k = 0; k < 100; k++) begin
      rd(2'd3, s);
      if (s == 0) break;
    end
  endtask

  task automatic wait_pulses(input int n, input int limit, output bit ok);
    int target;
    target = pulses + n;
    for (int k = 0; k < limit && pulses < target; k++) @(negedge bus_clk);
    ok = (pulses >= target);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int  v;
    int  p0;
    bit  ok;
    arst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 16'd0;
    repeat (5) @(negedge bus_clk);
    arst_n = 1'b1;
    repeat (6) @(negedge bus_clk);

    // R1 reset state
    rd(2'd1, v); check("R1 divider after reset", v, 0);
    rd(2'd2, v); check("R1 reload after reset", v, 4095);
    rd(2'd3, v); check("R1 status after reset", v, 0);
    check("R1 wdg_rst after reset", int'(wdg_rst), 0);
    rd(2'd0, v); check("R11 command reads zero", v, 0);

    // R2 protected after reset
    wr(2'd1, 16'd2); wait_idle(); rd(2'd1, v); check("R2 locked divider write", v, 0);
    wr(2'd2, 16'd5); wait_idle(); rd(2'd2, v); check("R2 locked reload write", v, 4095);

    // R4 busy flags and dropped write while busy
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd3);
    rd(2'd3, v); check("R4 divider busy bit0", v, 1);
    wr(2'd1, 16'd5);
    rd(2'd1, v); check("R4 write while busy ignored", v, 3);
    wait_idle();
    rd(2'd3, v); check("R4 busy clears", v, 0);
    wr(2'd2, 16'd100);
    rd(2'd3, v); check("R4 reload busy bit1", v, 2);
    wait_idle();

    // R3 other key relocks
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'd7); wait_idle(); rd(2'd1, v); check("R3 relocked divider", v, 3);
    wr(2'd2, 16'd9); wait_idle(); rd(2'd2, v); check("R3 relocked reload", v, 100);

    // R6 no pulse before start
    repeat (600) @(negedge bus_clk);
    check("R6 no pulse before start", pulses, 0);

    // R5 R6 R10 period table
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'(VECS[i].code));
      wr(2'd2, 16'(VECS[i].rld));
      wait_idle();
      wr(2'd0, 16'h0000);
      if (i == 0) wr(2'd0, 16'hCCCC);
      wait_pulses(2, 5000, ok);
      check($sformatf("R5 R6 pulse seen vec %0d", i), int'(ok), 1);
      check($sformatf("R6 period vec %0d", i), last_int, int'(VECS[i].period));
    end

    // R8 pulse width
    check("R8 pulse width", last_width, RST_LEN);

    // R7 refresh holds off expiry
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd20);
    wait_idle();
    wr(2'd0, 16'h0000);
    wait_pulses(2, 5000, ok);
    p0 = pulses;
    for (int k = 0; k < 40; k++) begin
      wr(2'd0, 16'hAAAA);
      repeat (28) @(negedge bus_clk);
    end
    check("R7 no pulse while refreshed", pulses, p0);
    wait_pulses(1, 400, ok);
    check("R7 pulse after refresh stops", int'(ok), 1);

    // R9 cannot be stopped
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h5555);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'hFFFF);
    wait_pulses(2, 1000, ok);
    check("R9 pulses continue after keys", int'(ok), 1);

    // reset mid-run returns to idle
    arst_n = 1'b0;
    repeat (3) @(negedge bus_clk);
    check("R1 wdg_rst low in reset", int'(wdg_rst), 0);
    arst_n = 1'b1;
    repeat (6) @(negedge bus_clk);
    rd(2'd1, v); check("R1 divider after second reset", v, 0);
    p0 = pulses;
    repeat (800) @(negedge bus_clk);
    check("R6 idle after second reset", pulses, p0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule